// File: doc/BRIEF.md
# Fixed-Depth Hit Counter and Trigger Comparator

This block forms a fast first-level trigger decision from a bank of 64 channel hit flags. Each flag is a 1-bit value that is high while its channel reports a hit. The flags are assumed to be already stretched, so they all overlap in time. The block adds the flags into a hit count. It then compares that count with a programmable threshold and drives a single decision bit.

The sum is built as a balanced binary tree of two-input adders: 63 adders in six ranks. The first rank adds single bits and each later rank is one bit wider, up to a 7-bit total. Every channel therefore passes through exactly six adders. This keeps the delay from input to decision the same whichever channel completes the count. There is no register anywhere between the inputs and the outputs, so the decision follows the inputs after gate delay only.

Top module: `hit_tree_trigger`

## Requirements
- R1: `hit_count_o` equals the number of bits set in `hit_i`, and it follows the inputs combinationally, with no clock edge needed.
- R2: When no bit of `hit_i` is set, `hit_count_o` is 0.
- R3: When all 64 bits of `hit_i` are set, `hit_count_o` is 64 (binary 1000000), with no wrap to zero.
- R4: A single set bit on any one channel, from bit 0 to bit 63, gives `hit_count_o` = 1.
- R5: `trig_o` is 1 exactly when `hit_count_o`, read as an unsigned 7-bit number, is greater than or equal to `thresh_i`, read as an unsigned 7-bit number.
- R6: A `thresh_i` of 0 makes `trig_o` 1 for every hit pattern, including the empty one.
- R7: A `thresh_i` of 65 or more makes `trig_o` 0 for every hit pattern, including all 64 channels set.
- R8: With `hit_count_o` equal to `thresh_i`, `trig_o` is 1; with `hit_count_o` one less than `thresh_i`, `trig_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hit_i | input | 64 | Stretched hit flags, one per channel, high = hit |
| thresh_i | input | 7 | Minimum hit count that fires the trigger |
| hit_count_o | output | 7 | Number of channels currently hit (0 to 64) |
| trig_o | output | 1 | Fast trigger decision |

## Verification
A table of mixed patterns checks the count and the decision against a popcount computed by the bench. The table covers sparse, dense, alternating, split-half and edge-bit patterns, with thresholds chosen just above and just below each count. An empty pattern and a full pattern separate the zero end of the count from the top end, which needs the carry into bit 6. A single set bit walked across all 64 positions shows that every leaf of the tree reaches the total. Fixed thresholds of 0, 64, 65 and 127, together with random patterns placed at count equal to threshold and at count one below threshold, pin down the comparison boundary.

// File: rtl/hit_tree_pkg.sv
package hit_tree_pkg;

    localparam int N_CH    = 64;
    localparam int LEVELS  = $clog2(N_CH);
    localparam int CNT_W   = LEVELS + 1;

    typedef logic [N_CH-1:0]  hit_vec_t;
    typedef logic [CNT_W-1:0] hit_cnt_t;

    typedef struct packed {
        hit_cnt_t count;
        logic     fire;
    } trig_result_t;

    // nodes present in a given rank of the tree (rank 0 adds input bits)
    function automatic int rank_nodes(input int n_ch, input int rank);
        return n_ch >> (rank + 1);
    endfunction

endpackage

// File: rtl/hit_add_node.sv
module hit_add_node #(
    parameter int IN_W = 1
) (
    input  logic [IN_W-1:0] a_i,
    input  logic [IN_W-1:0] b_i,
    output logic [IN_W:0]   sum_o
);

    assign sum_o = {1'b0, a_i} + {1'b0, b_i};

endmodule

// File: rtl/hit_adder_tree.sv
module hit_adder_tree #(
    parameter int N = 64
) (
    input  logic [N-1:0]          bits_i,
    output logic [$clog2(N):0]    total_o
);

    localparam int DEPTH = $clog2(N);

    for (genvar lv = 0; lv < DEPTH; lv++) begin : g_rank
        localparam int NODES = N >> (lv + 1);
        localparam int IW    = lv + 1;

        logic [IW:0] s [NODES];

        for (genvar k = 0; k < NODES; k++) begin : g_node
            logic [IW-1:0] opa;
            logic [IW-1:0] opb;

            if (lv == 0) begin : g_leaf
                assign opa = bits_i[2*k];
                assign opb = bits_i[2*k+1];
            end else begin : g_inner
                assign opa = g_rank[lv-1].s[2*k];
                assign opb = g_rank[lv-1].s[2*k+1];
            end

            hit_add_node #(.IN_W(IW)) u_add (
                .a_i   (opa),
                .b_i   (opb),
                .sum_o (s[k])
            );
        end
    end

    assign total_o = g_rank[DEPTH-1].s[0];

endmodule

// File: rtl/hit_thresh_cmp.sv
module hit_thresh_cmp #(
    parameter int W = 7
) (
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] limit_i,
    output logic         fire_o
);

    always_comb begin
        fire_o = (count_i >= limit_i);
    end

endmodule

// File: rtl/hit_tree_trigger.sv
module hit_tree_trigger
    import hit_tree_pkg::*;
(
    input  logic [N_CH-1:0]  hit_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic [CNT_W-1:0] hit_count_o,
    output logic             trig_o
);

    trig_result_t res;
    hit_cnt_t     tree_sum;
    logic         cmp_fire;

    hit_adder_tree #(.N(N_CH)) u_tree (
        .bits_i  (hit_i),
        .total_o (tree_sum)
    );

    hit_thresh_cmp #(.W(CNT_W)) u_cmp (
        .count_i (tree_sum),
        .limit_i (thresh_i),
        .fire_o  (cmp_fire)
    );

    always_comb begin
        res.count = tree_sum;
        res.fire  = cmp_fire;
    end

    assign hit_count_o = res.count;
    assign trig_o      = res.fire;

endmodule

// File: rtl/hit_tree_trigger_chk.sv
module hit_tree_trigger_chk
    import hit_tree_pkg::*;
(
    input logic [N_CH-1:0]  hit_i,
    input logic [CNT_W-1:0] thresh_i,
    input logic [CNT_W-1:0] hit_count_o,
    input logic             trig_o
);

    int ones;

    always_comb begin
        ones = $countones(hit_i);
        AST_COUNT_MATCH:   assert (int'(hit_count_o) == ones);                          // R1
        AST_EMPTY_ZERO:    assert (!(hit_i == '0) || hit_count_o == '0);                 // R2
        AST_FULL_NO_WRAP:  assert (!(&hit_i) || int'(hit_count_o) == N_CH);              // R3
        AST_DECISION:      assert (trig_o == (ones >= int'(thresh_i)));                  // R5
        AST_ZERO_THRESH:   assert (!(thresh_i == '0) || trig_o);                         // R6
        AST_HIGH_THRESH:   assert (!(int'(thresh_i) > N_CH) || !trig_o);                 // R7
    end

endmodule

bind hit_tree_trigger hit_tree_trigger_chk u_chk (.*);

// File: tb/sim_hit_tree_trigger.sv
module sim_hit_tree_trigger;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] hit_i = '0;
    logic [6:0]  thresh_i = 7'd1;
    logic [6:0]  hit_count_o;
    logic        trig_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2ns clk = ~clk;

    hit_tree_trigger u0 (
        .hit_i       (hit_i),
        .thresh_i    (thresh_i),
        .hit_count_o (hit_count_o),
        .trig_o      (trig_o)
    );

    localparam int NV = 10;
    localparam logic [63:0] VEC_HIT [NV] = '{
        64'h0000_0000_0000_0001,
        64'h8000_0000_0000_0000,
        64'hAAAA_AAAA_AAAA_AAAA,
        64'h5555_5555_5555_5555,
        64'hFFFF_FFFF_0000_0000,
        64'h0000_0000_FFFF_FFFF,
        64'h8000_0000_0000_0001,
        64'h0123_4567_89AB_CDEF,
        64'hFFFF_FFFF_FFFF_FFFE,
        64'h0000_1000_0040_0200
    };
    localparam logic [6:0] VEC_TH [NV] = '{
        7'd1, 7'd2, 7'd32, 7'd33, 7'd31, 7'd32, 7'd3, 7'd32, 7'd63, 7'd4
    };

    function automatic int ref_pop(input logic [63:0] v);
        int c = 0;
        for (int i = 0; i < 64; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [63:0] h, input logic [6:0] t);
        @(negedge clk);
        hit_i    = h;
        thresh_i = t;
        #1ns;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400us;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        // reset state: quiet inputs give zero count and no trigger
        #1ns;
        check("R2 reset count", int'(hit_count_o), 0);
        check("R5 reset trig", int'(trig_o), 0);
        @(negedge clk);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            int e;
            apply(VEC_HIT[i], VEC_TH[i]);
            e = ref_pop(VEC_HIT[i]);
            check("R1 table count", int'(hit_count_o), e);
            check("R5 table trig", int'(trig_o), int'(e >= int'(VEC_TH[i])));
        end

        // empty and full
        apply('0, 7'd1);
        check("R2 empty count", int'(hit_count_o), 0);
        check("R5 empty trig", int'(trig_o), 0);
        apply('1, 7'd64);
        check("R3 full count", int'(hit_count_o), 64);
        check("R8 full at equal thresh", int'(trig_o), 1);

        // one-hot walk
        for (int c = 0; c < 64; c++) begin
            apply(64'd1 << c, 7'd2);
            check($sformatf("R4 one-hot ch%0d count", c), int'(hit_count_o), 1);
            check($sformatf("R5 one-hot ch%0d trig", c), int'(trig_o), 0);
        end

        // zero threshold
        apply('0, 7'd0);
        check("R6 zero thresh empty", int'(trig_o), 1);
        apply(64'hDEAD_BEEF_0000_0000, 7'd0);
        check("R6 zero thresh pattern", int'(trig_o), 1);

        // thresholds beyond the range
        apply('1, 7'd65);
        check("R7 thresh 65 full", int'(trig_o), 0);
        apply('1, 7'd127);
        check("R7 thresh 127 full", int'(trig_o), 0);

        // random patterns at the comparison boundary
        for (int r = 0; r < 40; r++) begin
            logic [63:0] h;
            int e;
            h = {$urandom(), $urandom()};
            e = ref_pop(h);
            apply(h, 7'(e));
            check("R1 random count", int'(hit_count_o), e);
            check("R8 random equal", int'(trig_o), 1);
            apply(h, 7'(e + 1));
            check("R8 random one short", int'(trig_o), 0);
        end

        finish_run();
    end

endmodule